// File: doc/BRIEF.md
# Byte-Lane Write Delay Calibration Sequencer

This block tunes the write-data delay of a multi-lane memory interface, one byte lane at a time. For the selected lane it drives a fine delay tap value and sweeps it upward from zero. At each tap it waits a programmable settle time. It then accepts a pass/fail verdict from an external write-then-readback pattern checker. The sweep stops at the first edge of the passing data window or at the top of the tap range. The lane is then programmed to the centre of the passing window, and that value is kept in a per-lane result register. After the last lane, the block asks the read calibration logic to run again. It reports completion only when that handshake finishes.

The compare verdict arrives over a valid/ready channel. `cmp_ready_o` is high only while the sequencer is waiting for a verdict on the present tap. A verdict is taken on a clock edge where both `cmp_valid_i` and `cmp_ready_o` are high. The checker may hold `cmp_valid_i` low for as long as it needs, which applies back-pressure. During that time the sequencer keeps the tap and the ready level unchanged. The read recalibration request is a level that stays high until it is acknowledged. Start, mode, done and error are plain control and status pins.

Top module: `wrcal_seq`

## Requirements
- R1: Lanes are calibrated in order 0, 1, … LANES-1, and `lane_o` only steps up by one or returns to 0 on a new start. Each lane's result depends only on the verdicts received while that lane is selected.
- R2: On entering a lane, `tap_o` is loaded with the default 32. With `mode_i`=1 (reduced flow) the default is held for exactly 1 cycle. With `mode_i`=0 (full flow) it is held for `settle_i`+1 cycles, after which `tap_o` becomes 0.
- R3: A sweep starts at tap 0, and each accepted verdict that does not end the sweep raises `tap_o` by exactly one.
- R4: A sweep ends at the first failing verdict after at least one pass, or at the verdict taken at tap 63. The lane result is floor((first pass + last pass)/2).
- R5: `tap_o` never exceeds the tap limit of 63 and saturates there.
- R6: `cmp_ready_o` first rises `settle_i`+1 cycles after `tap_o` changes. While `cmp_valid_i` is low, `cmp_ready_o` and `tap_o` hold.
- R7: A lane with no passing tap sets `err_o` and stores the result 32, and the sequence moves on to the next lane. `err_o` stays set until the next start.
- R8: After the last lane, `rdcal_req_o` stays high until `rdcal_ack_i`. `done_o` rises on the cycle after the acknowledge is sampled, is never high together with `rdcal_req_o`, and stays high until the next start.
- R9: `rd_tap_o` returns the stored result of lane `rd_lane_i`. Every result resets to 32.
- R10: `start_i` is ignored while a calibration is in progress.
- R11: After reset: `tap_o`=32, `lane_o`=0, and `done_o`, `err_o`, `cmp_ready_o`, `rdcal_req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a calibration pass when idle or done |
| mode_i | input | 1 | 1 = reduced flow (no hold at default), 0 = full flow |
| settle_i | input | SETTLE_W | Settle cycles after each tap change |
| lane_o | output | LANE_W | Currently selected byte lane |
| tap_o | output | TAP_W | Tap value for the selected lane |
| cmp_valid_i | input | 1 | Compare verdict valid |
| cmp_pass_i | input | 1 | Compare verdict: 1 = pattern matched |
| cmp_ready_o | output | 1 | Sequencer ready to take a verdict |
| rdcal_req_o | output | 1 | Read recalibration request |
| rdcal_ack_i | input | 1 | Read recalibration (including read-valid step) finished |
| done_o | output | 1 | Calibration complete |
| err_o | output | 1 | A lane found no passing tap |
| rd_lane_i | input | LANE_W | Lane whose result is read |
| rd_tap_o | output | TAP_W | Stored final tap of `rd_lane_i` |

## Verification
Two events can land in the same cycle. The first is a passing verdict taken exactly at tap 63, where the tap limit and a window update coincide. This is provoked with a window that reaches the top of the range, and it is judged by the stored midpoint using 63 as the last pass. The second is an acknowledge that is already high when the request rises. This is provoked by tying the acknowledge high, and it is judged by the request lasting one cycle and done following without overlap. Stalled verdicts, windows that start at tap 0, double windows and lanes with no pass are also run.

// File: rtl/wrcal_pkg.sv
package wrcal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_SETTLE,
    ST_WAIT,
    ST_FINAL,
    ST_RDREQ,
    ST_DONE
  } wrcal_state_e;
endpackage

// File: rtl/wrcal_settle.sv
// Down-counter that paces tap changes: loaded with the settle count, reports zero.
module wrcal_settle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= cnt_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/wrcal_window.sv
// Tracks first and last passing taps of the current sweep and their midpoint.
module wrcal_window #(
  parameter int TAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             upd_i,
  input  logic             pass_i,
  input  logic [TAP_W-1:0] tap_i,
  output logic             seen_o,
  output logic [TAP_W-1:0] mid_o
);
  logic             seen_q;
  logic [TAP_W-1:0] first_q, last_q;
  logic [TAP_W:0]   sum;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q  <= 1'b0;
      first_q <= '0;
      last_q  <= '0;
    end else if (clr_i) begin
      seen_q  <= 1'b0;
    end else if (upd_i && pass_i) begin
      if (!seen_q) first_q <= tap_i;
      last_q <= tap_i;
      seen_q <= 1'b1;
    end
  end

  assign sum    = {1'b0, first_q} + {1'b0, last_q};
  assign mid_o  = sum[TAP_W:1];
  assign seen_o = seen_q;
endmodule

// File: rtl/wrcal_results.sv
// Per-lane final tap store with a read port.
module wrcal_results #(
  parameter int LANES     = 4,
  parameter int TAP_W     = 6,
  parameter int LANE_W    = 2,
  parameter int RESET_TAP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [LANE_W-1:0] wr_lane_i,
  input  logic [TAP_W-1:0]  wr_tap_i,
  input  logic [LANE_W-1:0] rd_lane_i,
  output logic [TAP_W-1:0]  rd_tap_o
);
  localparam logic [TAP_W-1:0] RST_V = TAP_W'(RESET_TAP);

  logic [TAP_W-1:0] store_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        store_q[g] <= RST_V;
      else if (wr_en_i && (int'(wr_lane_i) == g))
        store_q[g] <= wr_tap_i;
    end
  end

  assign rd_tap_o = (int'(rd_lane_i) < LANES) ? store_q[rd_lane_i] : RST_V;
endmodule

// File: rtl/wrcal_seq.sv
module wrcal_seq #(
  parameter int LANES       = 4,
  parameter int TAP_W       = 6,
  parameter int TAP_LIMIT   = 63,
  parameter int DEFAULT_TAP = 32,
  parameter int SETTLE_W    = 8,
  parameter int LANE_W      = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [SETTLE_W-1:0] settle_i,
  output logic [LANE_W-1:0]   lane_o,
  output logic [TAP_W-1:0]    tap_o,
  input  logic                cmp_valid_i,
  input  logic                cmp_pass_i,
  output logic                cmp_ready_o,
  output logic                rdcal_req_o,
  input  logic                rdcal_ack_i,
  output logic                done_o,
  output logic                err_o,
  input  logic [LANE_W-1:0]   rd_lane_i,
  output logic [TAP_W-1:0]    rd_tap_o
);
  import wrcal_pkg::*;

  localparam logic [TAP_W-1:0]  LIM       = TAP_W'(TAP_LIMIT);
  localparam logic [TAP_W-1:0]  DEF       = TAP_W'(DEFAULT_TAP);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  wrcal_state_e      state_q;
  logic [LANE_W-1:0] lane_q;
  logic [TAP_W-1:0]  tap_q;
  logic              err_q;

  logic accept, at_lim, edge_hit, sweep_end, step, start_ok, leave_load;
  logic cnt_load, cnt_zero, win_seen, res_we;
  logic [TAP_W-1:0] win_mid, final_tap;

  assign start_ok   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign accept     = (state_q == ST_WAIT) && cmp_valid_i;
  assign at_lim     = (tap_q >= LIM);
  assign edge_hit   = accept && !cmp_pass_i && win_seen;
  assign sweep_end  = accept && (edge_hit || at_lim);
  assign step       = accept && !sweep_end;
  assign leave_load = (state_q == ST_LOAD) && (mode_i || cnt_zero);
  assign cnt_load   = start_ok || leave_load || step ||
                      ((state_q == ST_FINAL) && (lane_q != LAST_LANE));
  assign res_we     = (state_q == ST_FINAL);
  assign final_tap  = win_seen ? win_mid : DEF;

  wrcal_settle #(.CNT_W(SETTLE_W)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (cnt_load),
    .cnt_i  (settle_i),
    .zero_o (cnt_zero)
  );

  wrcal_window #(.TAP_W(TAP_W)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (leave_load),
    .upd_i  (accept),
    .pass_i (cmp_pass_i),
    .tap_i  (tap_q),
    .seen_o (win_seen),
    .mid_o  (win_mid)
  );

  wrcal_results #(
    .LANES(LANES), .TAP_W(TAP_W), .LANE_W(LANE_W), .RESET_TAP(DEFAULT_TAP)
  ) u_results (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (res_we),
    .wr_lane_i (lane_q),
    .wr_tap_i  (final_tap),
    .rd_lane_i (rd_lane_i),
    .rd_tap_o  (rd_tap_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      tap_q   <= DEF;
      err_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE: begin
          if (start_ok) begin
            state_q <= ST_LOAD;
            lane_q  <= '0;
            tap_q   <= DEF;
            err_q   <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (leave_load) begin
            tap_q   <= '0;
            state_q <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (cnt_zero) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (sweep_end) begin
            state_q <= ST_FINAL;
          end else if (step) begin
            tap_q   <= tap_q + 1'b1;
            state_q <= ST_SETTLE;
          end
        end
        ST_FINAL: begin
          if (!win_seen) err_q <= 1'b1;
          if (lane_q == LAST_LANE) begin
            tap_q   <= final_tap;
            state_q <= ST_RDREQ;
          end else begin
            lane_q  <= lane_q + 1'b1;
            tap_q   <= DEF;
            state_q <= ST_LOAD;
          end
        end
        ST_RDREQ: begin
          if (rdcal_ack_i) state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign lane_o      = lane_q;
  assign tap_o       = tap_q;
  assign err_o       = err_q;
  assign cmp_ready_o = (state_q == ST_WAIT);
  assign rdcal_req_o = (state_q == ST_RDREQ);
  assign done_o      = (state_q == ST_DONE);
endmodule

// File: rtl/wrcal_seq_chk.sv
module wrcal_seq_chk #(
  parameter int TAP_W     = 6,
  parameter int LANE_W    = 2,
  parameter int TAP_LIMIT = 63
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LANE_W-1:0] lane_o,
  input logic [TAP_W-1:0]  tap_o,
  input logic              cmp_ready_o,
  input logic              cmp_valid_i,
  input logic              rdcal_req_o,
  input logic              rdcal_ack_i,
  input logic              done_o
);
  // R1: lane only steps up by one or restarts at zero
  a_r1_lane_step: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_o != $past(lane_o)) |->
      (lane_o == LANE_W'($past(lane_o) + 1'b1)) || (lane_o == '0));

  // R5: tap stays inside the fine-delay range
  a_r5_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tap_o) <= TAP_LIMIT);

  // R6: ready never rises in the same cycle the tap moves
  a_r6_ready_after_change: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_ready_o) |-> $stable(tap_o));

  // R6: back-pressure holds ready and tap
  a_r6_ready_held: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ready_o && !cmp_valid_i) |=> (cmp_ready_o && $stable(tap_o)));

  // R8: request held until acknowledged
  a_r8_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rdcal_req_o && !rdcal_ack_i) |=> rdcal_req_o);

  // R8: done only follows an acknowledge
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(rdcal_ack_i) && $past(rdcal_req_o)));

  // R8: done and request are exclusive; no verdict taken once done
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && (rdcal_req_o || cmp_ready_o)));
endmodule

bind wrcal_seq wrcal_seq_chk #(
  .TAP_W(TAP_W), .LANE_W(LANE_W), .TAP_LIMIT(TAP_LIMIT)
) u_chk (.*);

// File: tb/wrcal_seq_tb_top.sv
module wrcal_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int LANE_W = 2;
  localparam int NVEC   = 7;

  // vector: [73:10] pass mask, [9] mode, [8:1] settle, [0] stall
  localparam logic [73:0] VECS [NVEC] = '{
    {64'h0000_0000_001F_FC00, 1'b1, 8'd0, 1'b0},
    {64'hFFFF_FF00_0000_0000, 1'b0, 8'd3, 1'b0},
    {64'h0000_01FF_C000_01E0, 1'b1, 8'd2, 1'b1},
    {64'h0000_0000_0000_0000, 1'b0, 8'd1, 1'b0},
    {64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 8'd0, 1'b0},
    {64'h0004_0000_0000_0000, 1'b0, 8'd5, 1'b1},
    {64'h0000_0000_0000_0002, 1'b1, 8'd1, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [7:0] settle_i = '0;
  logic [LANE_W-1:0] lane_o;
  logic [5:0] tap_o;
  logic cmp_valid_i, cmp_pass_i, cmp_ready_o;
  logic rdcal_req_o, done_o, err_o;
  logic ack_reg = 1'b0, ack_tie = 1'b0;
  logic rdcal_ack_i;
  logic [LANE_W-1:0] rd_lane_i = '0;
  logic [5:0] rd_tap_o;

  logic [63:0] cur_mask = '0;
  logic        stall = 1'b0;
  logic [63:0] lane_mask;
  logic [31:0] cyc = '0;

  int n_chk = 0, n_err = 0;
  int hs_lane, hs_tap, chg_cnt, settle_bad, seq_bad;
  logic [5:0] prev_tap;
  logic prev_ready;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign lane_mask   = cur_mask >> {lane_o, 1'b0};
  assign cmp_pass_i  = lane_mask[tap_o];
  assign cmp_valid_i = !stall || cyc[0];
  assign rdcal_ack_i = ack_reg || ack_tie;

  wrcal_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .settle_i(settle_i), .lane_o(lane_o), .tap_o(tap_o),
    .cmp_valid_i(cmp_valid_i), .cmp_pass_i(cmp_pass_i),
    .cmp_ready_o(cmp_ready_o), .rdcal_req_o(rdcal_req_o),
    .rdcal_ack_i(rdcal_ack_i), .done_o(done_o), .err_o(err_o),
    .rd_lane_i(rd_lane_i), .rd_tap_o(rd_tap_o)
  );

  // Port monitor: settle spacing (R6) and sweep order (R1, R3)
  always @(negedge clk) begin
    if (!rst_n) begin
      chg_cnt = 0; prev_tap = tap_o; prev_ready = 1'b0;
    end else begin
      if (tap_o != prev_tap) chg_cnt = 0; else chg_cnt = chg_cnt + 1;
      if (cmp_ready_o && !prev_ready && chg_cnt != int'(settle_i) + 1)
        settle_bad = settle_bad + 1;
      if (cmp_ready_o && cmp_valid_i) begin
        if (int'(lane_o) != hs_lane) begin
          if (int'(lane_o) != hs_lane + 1 || tap_o != 0) seq_bad = seq_bad + 1;
        end else if (int'(tap_o) != hs_tap + 1) seq_bad = seq_bad + 1;
        hs_lane = int'(lane_o); hs_tap = int'(tap_o);
      end
      prev_tap = tap_o; prev_ready = cmp_ready_o;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic exp_lane(input logic [63:0] mask, input int lane,
                          output int tap, output bit nopass);
    logic [63:0] m;
    int first, last;
    bit seen;
    m = mask >> (2 * lane);
    seen = 0; first = 0; last = 0;
    for (int t = 0; t < 64; t++) begin
      if (m[t]) begin
        if (!seen) first = t;
        last = t; seen = 1;
      end else if (seen) break;
    end
    nopass = !seen;
    tap = seen ? (first + last) / 2 : 32;
  endtask

  task automatic run_cal(input logic [63:0] mask, input bit md, input int st,
                         input bit stl, input int ack_dly, input int poke);
    int hold, e_tap;
    bit nop, any_err, poked, early;
    cur_mask = mask; mode_i = md; settle_i = 8'(st); stall = stl;
    hs_lane = -1; hs_tap = 0; settle_bad = 0; seq_bad = 0;
    poked = 0; early = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    hold = 0;
    while (tap_o == 6'd32 && lane_o == 0) begin hold++; @(negedge clk); end
    check(hold == (md ? 1 : st + 1), "R2 default hold", hold, md ? 1 : st + 1);
    while (!rdcal_req_o && !done_o) begin
      start_i = (poke >= 0 && int'(lane_o) == poke && !poked);
      if (start_i) poked = 1;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (!ack_tie) begin
      for (int k = 0; k < ack_dly; k++) begin
        if (done_o || !rdcal_req_o) early = 1;
        @(negedge clk);
      end
      check(!early, "R8 req held, no early done", early, 0);
      ack_reg = 1'b1; @(negedge clk); ack_reg = 1'b0;
    end else begin
      @(negedge clk);
    end
    check(done_o && !rdcal_req_o, "R8 done after ack", done_o, 1);
    check(seq_bad == 0, "R3 sweep order/R1 lane order", seq_bad, 0);
    check(settle_bad == 0, "R6 settle spacing", settle_bad, 0);
    any_err = 0;
    for (int l = 0; l < LANES; l++) begin
      exp_lane(mask, l, e_tap, nop);
      any_err |= nop;
      rd_lane_i = LANE_W'(l);
      @(negedge clk);
      check(int'(rd_tap_o) == e_tap, $sformatf("R4 R9 lane %0d result", l),
            rd_tap_o, e_tap);
    end
    check(err_o == any_err, "R7 error flag", err_o, any_err);
    repeat (4) @(negedge clk);
    check(done_o, "R8 done persists", done_o, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8 watchdog: done actual=%0d expected=1", done_o);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(tap_o == 6'd32, "R11 reset tap", tap_o, 32);
    check(lane_o == 0, "R11 reset lane", lane_o, 0);
    check(!done_o && !err_o && !cmp_ready_o && !rdcal_req_o,
          "R11 reset flags", {done_o, err_o, cmp_ready_o, rdcal_req_o}, 0);
    for (int l = 0; l < LANES; l++) begin
      rd_lane_i = LANE_W'(l); @(negedge clk);
      check(rd_tap_o == 6'd32, "R9 reset result", rd_tap_o, 32);
    end
    // table walk
    for (int v = 0; v < NVEC; v++)
      run_cal(VECS[v][73:10], VECS[v][9], int'(VECS[v][8:1]), VECS[v][0], 2, -1);
    // R10: start pulsed while lane 2 calibrates is ignored
    run_cal(64'h0000_0FFF_F000_0000, 1'b0, 1, 1'b0, 1, 2);
    // R8: acknowledge already high when the request rises
    ack_tie = 1'b1;
    run_cal(64'h0000_0000_0000_FF00, 1'b1, 0, 1'b0, 0, -1);
    ack_tie = 1'b0;
    // R5: window at the top of the range, lane 0 ends at the limit
    run_cal(64'h8000_0000_0000_0000, 1'b1, 0, 1'b1, 3, -1);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule